// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block sits between a requester and the page table in memory and caches recent virtual-to-physical page translations. A lookup presents a virtual page number. When a resident entry matches, the physical frame number comes back combinationally in the same cycle. When nothing matches, the block raises a walk request carrying the page number and the address of the page-table entry. That address is the page-table base input plus four bytes per page.

An external walker returns a refill. The refill holds either a frame number or a fault flag. A good refill is installed. A faulting refill is never cached, and the block reports the fault to the requester on the following cycle. A refill for a page that is already resident rewrites that entry in place. Otherwise the refill fills an empty slot if one exists; if every slot is full, it evicts a victim chosen from a free-running 16-bit LFSR. A write that hits marks its entry dirty. A flush input invalidates every entry at once.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid and `lk_hit`, `lk_miss`, `walk_req` and `fault_o` are 0.
- R2: While `lk_req` is 1, exactly one of `lk_hit` and `lk_miss` is 1. While `lk_req` is 0, both are 0.
- R3: On a hit, `lk_frame` equals the frame installed for that page number in the same cycle. On a miss or with no request, `lk_frame` is 0.
- R4: On a miss, `walk_req` is 1 in the same cycle, `walk_vpn` equals `lk_vpn`, and `walk_addr` equals `ptbr + 4*lk_vpn` modulo 2^32.
- R5: A refill with `fill_fault` = 0 installs the translation, so a lookup in the next cycle hits with that frame.
- R6: A refill with `fill_fault` = 1 installs nothing and evicts nothing. `fault_o` is 1 for exactly the next cycle.
- R7: While an empty entry exists, a refill of a new page number takes an empty entry, so eight distinct refills after a flush all remain resident.
- R8: When all eight entries are valid, a refill of a new page number evicts exactly one resident entry, and the new page then hits.
- R9: A refill whose page number is already resident overwrites that entry's frame and clears its dirty bit. No other entry changes.
- R10: A lookup with `lk_write` = 1 that hits sets the entry's dirty bit. A read hit leaves it unchanged. `lk_dirty` shows the hit entry's dirty bit as it stood before the current cycle.
- R11: `flush` invalidates all entries in one cycle and takes priority over a refill in the same cycle.
- R12: No page number ever matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent |
| lk_frame | output | 20 | Physical frame number on a hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| ptbr | input | 32 | Page-table base address |
| walk_req | output | 1 | Page-table fetch request |
| walk_vpn | output | 20 | Page number to fetch |
| walk_addr | output | 32 | Address of the page-table entry |
| fill_valid | input | 1 | Refill response strobe |
| fill_vpn | input | 20 | Page number of the refill |
| fill_frame | input | 20 | Frame number of the refill |
| fill_fault | input | 1 | Refill reports page not present |
| flush | input | 1 | Invalidate all entries |
| fault_o | output | 1 | Page fault reported to the requester |

## Verification
The hardest state to reach from the ports is a full buffer. In that state a refill must either replace exactly one entry at a pseudo-random slot, or, when it faults, leave every entry untouched. The bench gets there by flushing, then sweeping eight distinct page numbers through refills. It confirms the buffer is full by looking each one up. It then sends a faulting refill and a fresh good refill, and counts how many of the original eight still hit. Because the victim index cannot be predicted, the bench does not check which entry goes. It checks that exactly one does.

// File: rtl/tlb_fa_pkg.sv
// Shared constants and helpers for the translation buffer.
package tlb_fa_pkg;
    localparam int PTE_SHIFT = 2;   // each page-table entry occupies four bytes

    // Returns the index of the lowest set bit of a vector (0 if none set).
    function automatic int unsigned lowest_set(input logic [63:0] v, input int unsigned n);
        int unsigned r;
        r = 0;
        for (int i = int'(n) - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_fa_lfsr.sv
// Free-running 16-bit Fibonacci LFSR supplying a pseudo-random slot index.
// Assumes IDX_W <= 16; seed is a non-zero constant restored on reset.
module tlb_fa_lfsr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] rnd_idx
);
    logic [15:0] state_q;
    logic        fb;

    // Feedback from taps 16,14,13,11 (maximal length polynomial).
    always_comb fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

    // Advance one step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= 16'hACE1;
        else        state_q <= {state_q[14:0], fb};
    end

    assign rnd_idx = state_q[IDX_W-1:0];
endmodule

// File: rtl/tlb_fa_victim.sv
// Chooses the slot a new translation goes into: the lowest empty slot if
// any exists, otherwise the pseudo-random index. Purely combinational.
module tlb_fa_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [IDX_W-1:0] rnd_idx,
    output logic [IDX_W-1:0] victim
);
    import tlb_fa_pkg::*;
    logic [63:0] empty_w;

    // Prefer an invalid entry over an eviction.
    always_comb begin
        empty_w = '0;
        empty_w[N-1:0] = ~valid_vec;
        if (|empty_w) victim = IDX_W'(lowest_set(empty_w, N));
        else          victim = rnd_idx;
    end
endmodule

// File: rtl/tlb_fa_cam.sv
// Entry storage with parallel tag compare for the lookup port and the refill
// port. Assumes the caller never installs a tag already held by another slot.
module tlb_fa_cam #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int VPN_W = 20,
    parameter int FRM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             set_dirty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [FRM_W-1:0] fill_frame,
    output logic [N-1:0]     lk_match,
    output logic [N-1:0]     fl_match,
    output logic [N-1:0]     valid_vec,
    output logic [N-1:0]     dirty_vec,
    output logic [FRM_W-1:0] hit_frame,
    output logic             hit_dirty
);
    logic [VPN_W-1:0] tag_q   [N];
    logic [FRM_W-1:0] frame_q [N];

    // One comparator pair per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_match[g] = valid_vec[g] && (tag_q[g] == lk_vpn);
        assign fl_match[g] = valid_vec[g] && (tag_q[g] == fill_vpn);
    end

    // Mux out the frame and dirty bit of the (single) matching entry.
    always_comb begin
        hit_frame = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                hit_frame = hit_frame | frame_q[i];
                hit_dirty = hit_dirty | dirty_vec[i];
            end
        end
    end

    // Update state: flush wins; refill overrides a same-cycle dirty set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_vec <= '0;
            dirty_vec <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i]   <= '0;
                frame_q[i] <= '0;
            end
        end else if (flush) begin
            valid_vec <= '0;
        end else begin
            if (set_dirty) dirty_vec <= dirty_vec | lk_match;
            if (fill_en) begin
                valid_vec[fill_idx] <= 1'b1;
                tag_q[fill_idx]     <= fill_vpn;
                frame_q[fill_idx]   <= fill_frame;
                dirty_vec[fill_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_fa.sv
// Top of the fully associative translation buffer. Lookup is combinational;
// misses drive a page-table fetch request; refills install or report a fault.
// Assumes the walker returns a refill only for page numbers it was asked for.
module tlb_fa #(
    parameter int N      = 8,
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int FRM_W  = 20,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_req,
    input  logic [VA_W-PAGE_W-1:0] lk_vpn,
    input  logic                 lk_write,
    output logic                 lk_hit,
    output logic                 lk_miss,
    output logic [FRM_W-1:0]     lk_frame,
    output logic                 lk_dirty,
    input  logic [ADDR_W-1:0]    ptbr,
    output logic                 walk_req,
    output logic [VA_W-PAGE_W-1:0] walk_vpn,
    output logic [ADDR_W-1:0]    walk_addr,
    input  logic                 fill_valid,
    input  logic [VA_W-PAGE_W-1:0] fill_vpn,
    input  logic [FRM_W-1:0]     fill_frame,
    input  logic                 fill_fault,
    input  logic                 flush,
    output logic                 fault_o
);
    import tlb_fa_pkg::*;
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]     lk_match, fl_match, ent_valid, ent_dirty;
    logic [FRM_W-1:0] hit_frame;
    logic             hit_dirty, any_hit, fill_en, set_dirty;
    logic [IDX_W-1:0] rnd_idx, victim, fill_idx;
    logic [63:0]      fl_match_w;

    tlb_fa_lfsr #(.IDX_W(IDX_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd_idx(rnd_idx)
    );

    tlb_fa_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .valid_vec(ent_valid), .rnd_idx(rnd_idx), .victim(victim)
    );

    tlb_fa_cam #(.N(N), .IDX_W(IDX_W), .VPN_W(VPN_W), .FRM_W(FRM_W)) u_cam (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_vpn(lk_vpn),
        .set_dirty(set_dirty), .fill_en(fill_en), .fill_idx(fill_idx),
        .fill_vpn(fill_vpn), .fill_frame(fill_frame), .lk_match(lk_match),
        .fl_match(fl_match), .valid_vec(ent_valid), .dirty_vec(ent_dirty),
        .hit_frame(hit_frame), .hit_dirty(hit_dirty)
    );

    // Lookup result, qualified by the request.
    always_comb begin
        any_hit  = |lk_match;
        lk_hit   = lk_req && any_hit;
        lk_miss  = lk_req && !any_hit;
        lk_frame = lk_hit ? hit_frame : '0;
        lk_dirty = lk_hit && hit_dirty;
        set_dirty = lk_hit && lk_write;
    end

    // Page-table fetch request: entry address is base plus four bytes per page.
    always_comb begin
        walk_req  = lk_miss;
        walk_vpn  = lk_vpn;
        walk_addr = ptbr + (ADDR_W'(lk_vpn) << PTE_SHIFT);
    end

    // Refill slot: rewrite in place when resident, else take the victim.
    always_comb begin
        fill_en    = fill_valid && !fill_fault;
        fl_match_w = '0;
        fl_match_w[N-1:0] = fl_match;
        fill_idx   = (|fl_match) ? IDX_W'(lowest_set(fl_match_w, N)) : victim;
    end

    // Report a faulting refill to the requester one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_o <= 1'b0;
        else        fault_o <= fill_valid && fill_fault;
    end
endmodule

// File: rtl/tlb_fa_chk.sv
// Property checker for tlb_fa, attached through bind.
module tlb_fa_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_req,
    input logic         lk_write,
    input logic         lk_hit,
    input logic         lk_miss,
    input logic         walk_req,
    input logic         fill_valid,
    input logic         fill_fault,
    input logic         flush,
    input logic         fault_o,
    input logic [N-1:0] lk_match,
    input logic [N-1:0] ent_valid,
    input logic [N-1:0] ent_dirty
);
    p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) == lk_req && !(lk_hit && lk_miss));

    p_walk_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> walk_req);

    p_fault_no_install_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_fault && !flush) |=> (ent_valid == $past(ent_valid)) && fault_o);

    p_write_sets_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_write && lk_hit && !fill_valid && !flush)
            |=> ((ent_dirty & $past(lk_match)) == $past(lk_match)));

    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    p_single_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind tlb_fa tlb_fa_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .walk_req(walk_req),
    .fill_valid(fill_valid), .fill_fault(fill_fault), .flush(flush),
    .fault_o(fault_o), .lk_match(lk_match), .ent_valid(ent_valid),
    .ent_dirty(ent_dirty)
);

// File: tb/tb_tlb_fa.sv
// Self-checking bench: sweeps fills, lookups, writes, faults and flushes.
module tb_tlb_fa;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_write = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_miss, lk_dirty, walk_req, fault_o;
    logic [19:0] lk_frame, walk_vpn;
    logic [31:0] ptbr = 32'h8000_0100, walk_addr;
    logic        fill_valid = 1'b0, fill_fault = 1'b0, flush = 1'b0;
    logic [19:0] fill_vpn = '0, fill_frame = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_fa dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_write(lk_write), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_frame(lk_frame), .lk_dirty(lk_dirty), .ptbr(ptbr),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_addr(walk_addr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
        .fill_fault(fill_fault), .flush(flush), .fault_o(fault_o)
    );

    function automatic logic [19:0] vpn_of(input int i);
        return 20'(32'h0_1230 + i * 32'h111);
    endfunction
    function automatic logic [19:0] frm_of(input int i);
        return 20'(i * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a refill for one cycle.
    task automatic refill(input logic [19:0] v, input logic [19:0] f, input logic flt);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_frame = f; fill_fault = flt;
        @(negedge clk);
        fill_valid = 1'b0; fill_fault = 1'b0;
    endtask

    // Present a lookup at a negedge; outputs settle before the next posedge.
    task automatic look(input logic [19:0] v, input logic wr);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = v; lk_write = wr;
        #1;
    endtask

    task automatic idle();
        lk_req = 1'b0; lk_write = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        look(vpn_of(0), 1'b0);
        chk("R1 hit after reset", 32'(lk_hit), 0);
        chk("R1 fault after reset", 32'(fault_o), 0);
        // R4: miss raises walk with computed address
        for (int i = 0; i < 4; i++) begin
            look(vpn_of(i * 5), 1'b0);
            chk("R4 walk_req", 32'(walk_req), 1);
            chk("R4 walk_vpn", 32'(walk_vpn), 32'(vpn_of(i * 5)));
            chk("R4 walk_addr", walk_addr, ptbr + 32'(vpn_of(i * 5)) * 4);
            chk("R3 frame on miss", 32'(lk_frame), 0);
        end
        idle();
        #1;
        // R2: no request, no hit/miss
        chk("R2 idle hit|miss", 32'(lk_hit | lk_miss), 0);
        // R5/R7: eight fills after reset all resident
        for (int i = 0; i < 8; i++) refill(vpn_of(i), frm_of(i), 1'b0);
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            chk("R7 resident after 8 fills", 32'(lk_hit), 1);
            chk("R5 R3 frame", 32'(lk_frame), 32'(frm_of(i)));
            chk("R2 miss low on hit", 32'(lk_miss), 0);
        end
        idle();
        // R10: write on even entries, then read back dirty bits
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            chk("R10 clean after install", 32'(lk_dirty), 0);
            if (i % 2 == 0) begin
                look(vpn_of(i), 1'b1);
                chk("R10 dirty shows prior value", 32'(lk_dirty), 0);
            end
        end
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            chk("R10 dirty after write", 32'(lk_dirty), (i % 2 == 0) ? 1 : 0);
        end
        idle();
        // R9: overwrite resident entry 2 (dirty) with a new frame
        refill(vpn_of(2), 20'hABCDE, 1'b0);
        look(vpn_of(2), 1'b0);
        chk("R9 new frame", 32'(lk_frame), 32'h000A_BCDE);
        chk("R9 dirty cleared", 32'(lk_dirty), 0);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            hits += int'(lk_hit);
        end
        chk("R9 others kept", 32'(hits), 8);
        look(vpn_of(4), 1'b0);
        chk("R9 neighbour dirty kept", 32'(lk_dirty), 1);
        idle();
        // R6: faulting refill when full installs nothing
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h7_7777; fill_frame = 20'h1; fill_fault = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; fill_fault = 1'b0;
        chk("R6 fault_o pulse", 32'(fault_o), 1);
        @(negedge clk);
        chk("R6 fault_o one cycle", 32'(fault_o), 0);
        look(20'h7_7777, 1'b0);
        chk("R6 fault not cached", 32'(lk_miss), 1);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            hits += int'(lk_hit);
        end
        chk("R6 nothing evicted", 32'(hits), 8);
        idle();
        // R8: a new page when full evicts exactly one
        refill(20'h5_5555, 20'h0_0042, 1'b0);
        look(20'h5_5555, 1'b0);
        chk("R8 new page hits", 32'(lk_hit), 1);
        chk("R8 new page frame", 32'(lk_frame), 32'h42);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            hits += int'(lk_hit);
        end
        chk("R8 exactly one evicted", 32'(hits), 7);
        idle();
        // R11: flush together with a refill; flush wins
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h6_6666; fill_frame = 20'h9;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i), 1'b0);
            hits += int'(lk_hit);
        end
        look(20'h5_5555, 1'b0);
        hits += int'(lk_hit);
        look(20'h6_6666, 1'b0);
        hits += int'(lk_hit);
        chk("R11 all invalid after flush", 32'(hits), 0);
        idle();
        // R7: after flush, eight new fills with a second pattern all resident
        for (int i = 0; i < 8; i++) refill(vpn_of(i + 20), frm_of(i + 20), 1'b0);
        hits = 0;
        for (int i = 0; i < 8; i++) begin
            look(vpn_of(i + 20), 1'b0);
            hits += int'(lk_hit && lk_frame == frm_of(i + 20));
        end
        chk("R7 refill after flush", 32'(hits), 8);
        idle();
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule